// File: doc/BRIEF.md
# Bus-Encoded Nonvolatile Command Detector

This block sits beside a byte-wide memory with a 13-bit address and active-low chip-enable and write-enable strobes. It watches the ordinary access traffic for a reserved series of six reads. When the series completes, it asks the transfer engine to copy the volatile array into nonvolatile storage (save) or to copy it back (restore). Because the command is carried by plain reads, software can issue it through the normal memory bus and needs no extra pins or registers.

An access is counted once, at the clock edge that first sees chip-enable low after it was high. The series has six steps. Steps one to five use the same addresses for both commands. The address of the sixth step chooses save or restore. A write, or a read from any address outside the series, ends the attempt. The one exception is a read of the first key address, which starts a new attempt at once.

The transfer engine supplies a busy flag, and a supply monitor supplies a low-supply flag. While busy is high, accesses are ignored and any partial progress is discarded. While low-supply is high, a save request is withheld, but a restore request is still issued. During the sixth access of a completed series, the block tells the memory to float its data bus. For steps one to five the memory returns its normal data.

Top module: `nvcmd_detect`

## Requirements
- R1: While rst_ni is low, save_req_o, restore_req_o and bus_hiz_o are all 0, and the series progress is cleared.
- R2: Reads of hex 0000, 1555, 0AAA, 1FFF, 10F0 and then 0F0F, taken as six consecutive accesses, raise save_req_o. It rises in the cycle after the clock edge that samples the sixth access.
- R3: The same first five reads followed by a read of hex 0F0E raise restore_req_o, with the same timing as R2.
- R4: An access with we_n_i low at any step produces no request and clears the series progress, whatever its address.
- R5: A read from any address that is not the expected next key clears the progress. If that address is hex 0000, it is instead counted as step one of a new series.
- R6: An access is counted only at a clock edge where ce_n_i is low and was high at the previous edge. Holding ce_n_i low over further edges counts no further access, even if the address changes.
- R7: While busy_i is high at a clock edge, no access is counted at that edge, no request follows, and the series progress is cleared.
- R8: When low_supply_i is high at the sixth access of a save series, save_req_o stays 0. A restore series still raises restore_req_o while low_supply_i is high.
- R9: bus_hiz_o rises in the cycle after a completed series of either kind, including a save withheld under R8. It stays high until the first clock edge that samples ce_n_i high. It is 0 during steps one to five.
- R10: Each request lasts exactly one cycle, and save_req_o and restore_req_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Memory chip enable, active low; its falling edge marks an access |
| we_n_i | input | 1 | Memory write enable, active low; must be high for a step to count |
| addr_i | input | ADDR_W | Memory address of the access |
| busy_i | input | 1 | Transfer engine busy; blocks detection and clears progress |
| low_supply_i | input | 1 | Low supply flag; withholds save requests |
| save_req_o | output | 1 | One-cycle request to copy the array into nonvolatile storage |
| restore_req_o | output | 1 | One-cycle request to copy nonvolatile storage into the array |
| bus_hiz_o | output | 1 | Data bus must float during the sixth access of a completed series |

## Verification
The bench uses the default 13-bit address width. At this width, every one of the 8192 possible addresses can be tried as the sixth access after a valid five-step prefix, so the only addresses that produce a request are known to be the two command keys. At the same width, an interrupting read and an interrupting write are each placed after every prefix length from one to five. Further directed series cover the restart on hex 0000, a chip-enable held low, busy at different points and the low-supply inhibit.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int unsigned KEY_W      = 13;
  localparam int unsigned NUM_PREFIX = 5;
  localparam int unsigned NUM_STEPS  = NUM_PREFIX + 1;
  localparam int unsigned PROG_W     = $clog2(NUM_STEPS);

  typedef logic [KEY_W-1:0] key_t;

  localparam key_t SAVE_KEY    = 13'h0F0F;
  localparam key_t RESTORE_KEY = 13'h0F0E;

  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_SAVE    = 2'd1,
    HIT_RESTORE = 2'd2
  } hit_e;

  // shared opening keys, in series order
  function automatic key_t prefix_key(input int unsigned idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/nvcmd_strobe.sv
module nvcmd_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  output logic fall_o
);
  logic ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_n_i;
  end

  assign fall_o = ce_q & ~ce_n_i;
endmodule

// File: rtl/nvcmd_seq.sv
module nvcmd_seq
  import nvcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              busy_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hit_e              hit_o
);
  localparam logic [PROG_W-1:0] LAST = PROG_W'(NUM_PREFIX);

  logic [NUM_PREFIX-1:0] pre_eq;
  logic                  save_eq, restore_eq, next_eq;
  logic [PROG_W-1:0]     prog_q, prog_d;

  for (genvar g = 0; g < NUM_PREFIX; g++) begin : g_key
    assign pre_eq[g] = (addr_i == ADDR_W'(prefix_key(g)));
  end

  assign save_eq    = (addr_i == ADDR_W'(SAVE_KEY));
  assign restore_eq = (addr_i == ADDR_W'(RESTORE_KEY));

  always_comb begin
    next_eq = 1'b0;
    for (int unsigned i = 0; i < NUM_PREFIX; i++)
      if (prog_q == PROG_W'(i)) next_eq = pre_eq[i];
  end

  always_comb begin
    prog_d = prog_q;
    hit_o  = HIT_NONE;
    if (busy_i) begin
      prog_d = '0;
    end else if (acc_i) begin
      if (!we_n_i) begin
        prog_d = '0;
      end else if (prog_q == LAST) begin
        if (save_eq) begin
          hit_o  = HIT_SAVE;
          prog_d = '0;
        end else if (restore_eq) begin
          hit_o  = HIT_RESTORE;
          prog_d = '0;
        end else begin
          prog_d = pre_eq[0] ? PROG_W'(1) : '0;
        end
      end else if (next_eq) begin
        prog_d = prog_q + PROG_W'(1);
      end else begin
        // a stray 0000 read opens a fresh series
        prog_d = pre_eq[0] ? PROG_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= '0;
    else         prog_q <= prog_d;
  end
endmodule

// File: rtl/nvcmd_req.sv
module nvcmd_req
  import nvcmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  hit_e hit_i,
  input  logic low_supply_i,
  input  logic ce_n_i,
  output logic save_req_o,
  output logic restore_req_o,
  output logic bus_hiz_o
);
  logic hit_any;
  assign hit_any = (hit_i != HIT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_req_o    <= 1'b0;
      restore_req_o <= 1'b0;
      bus_hiz_o     <= 1'b0;
    end else begin
      save_req_o    <= (hit_i == HIT_SAVE) & ~low_supply_i;
      restore_req_o <= (hit_i == HIT_RESTORE);
      if (hit_any)     bus_hiz_o <= 1'b1;
      else if (ce_n_i) bus_hiz_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nvcmd_detect.sv
module nvcmd_detect
  import nvcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              low_supply_i,
  output logic              save_req_o,
  output logic              restore_req_o,
  output logic              bus_hiz_o
);
  logic acc;
  hit_e hit;

  nvcmd_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_n_i (ce_n_i),
    .fall_o (acc)
  );

  nvcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .busy_i (busy_i),
    .we_n_i (we_n_i),
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  nvcmd_req u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hit_i         (hit),
    .low_supply_i  (low_supply_i),
    .ce_n_i        (ce_n_i),
    .save_req_o    (save_req_o),
    .restore_req_o (restore_req_o),
    .bus_hiz_o     (bus_hiz_o)
  );
endmodule

// File: rtl/nvcmd_detect_chk.sv
module nvcmd_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_n_i,
  input logic we_n_i,
  input logic busy_i,
  input logic low_supply_i,
  input logic save_req_o,
  input logic restore_req_o,
  input logic bus_hiz_o
);
  a_r10_save_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |=> !save_req_o);
  a_r10_restore_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |=> !restore_req_o);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_req_o && restore_req_o));
  a_r7_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(save_req_o || restore_req_o));
  a_r4_write_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |=> !(save_req_o || restore_req_o));
  a_r8_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> !save_req_o);
  a_r6_req_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o || restore_req_o) |-> $past(!ce_n_i));
  a_r9_hiz_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |=> !bus_hiz_o);
endmodule

bind nvcmd_detect nvcmd_detect_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ce_n_i        (ce_n_i),
  .we_n_i        (we_n_i),
  .busy_i        (busy_i),
  .low_supply_i  (low_supply_i),
  .save_req_o    (save_req_o),
  .restore_req_o (restore_req_o),
  .bus_hiz_o     (bus_hiz_o)
);

// File: tb/nvcmd_detect_tb.sv
`timescale 1ns/1ps
module nvcmd_detect_tb;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          busy = 1'b0;
  logic          lowsup = 1'b0;
  logic          save_req, restore_req, hiz;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvcmd_detect #(.ADDR_W(AW)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ce_n_i        (ce_n),
    .we_n_i        (we_n),
    .addr_i        (addr),
    .busy_i        (busy),
    .low_supply_i  (lowsup),
    .save_req_o    (save_req),
    .restore_req_o (restore_req),
    .bus_hiz_o     (hiz)
  );

  function automatic logic [AW-1:0] key(input int i);
    logic [AW-1:0] k [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    return k[i];
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  // kind: 0 none, 1 save series completes, 2 restore series completes
  task automatic acc(input logic [AW-1:0] a, input bit wr, input int kind, input string tag);
    @(negedge clk);
    ce_n = 1'b0; we_n = ~wr; addr = a;
    @(negedge clk);
    check(save_req, (kind == 1) && !lowsup, {tag, " save_req"});
    check(restore_req, kind == 2, {tag, " restore_req"});
    check(hiz, kind != 0, {tag, " bus_hiz"});
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    check(save_req, 1'b0, {tag, " save_req pulse end (R10)"});
    check(restore_req, 1'b0, {tag, " restore_req pulse end (R10)"});
    check(hiz, 1'b0, {tag, " bus_hiz release (R9)"});
  endtask

  task automatic prefix(input int from, input int upto, input string tag);
    for (int i = from; i < upto; i++) acc(key(i), 1'b0, 0, tag);
  endtask

  task automatic full_save(input string tag);
    prefix(0, 5, tag);
    acc(13'h0F0F, 1'b0, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(save_req, 1'b0, "R1 reset save_req");
    check(restore_req, 1'b0, "R1 reset restore_req");
    check(hiz, 1'b0, "R1 reset bus_hiz");
    rst_n = 1'b1;

    full_save("R2 save series");
    prefix(0, 5, "R3 restore prefix");
    acc(13'h0F0E, 1'b0, 2, "R3 restore series");

    // sweep of every sixth address (R2, R3, R5)
    for (int a = 0; a < (1 << AW); a++) begin
      int kind;
      kind = (a == 'h0F0F) ? 1 : (a == 'h0F0E) ? 2 : 0;
      prefix(0, 5, "R5 sweep prefix");
      acc(AW'(a), 1'b0, kind, "R2/R3/R5 sixth-address sweep");
    end

    // interrupt after every prefix length
    for (int k = 1; k <= 5; k++) begin
      prefix(0, k, "R5 abort prefix");
      acc(13'h0123, 1'b0, 0, "R5 stray read");
      prefix(k, 5, "R5 abort rest");
      acc(13'h0F0F, 1'b0, 0, "R5 aborted series");
      prefix(0, k, "R4 write prefix");
      acc((k < 5) ? key(k) : 13'h0F0F, 1'b1, 0, "R4 write in series");
      prefix(k, 5, "R4 write rest");
      acc(13'h0F0F, 1'b0, 0, "R4 aborted series");
      full_save("R5 recovery");
    end

    // write to key 0000 is not a restart
    acc(13'h0000, 1'b1, 0, "R4 write 0000");
    prefix(1, 5, "R4 no restart");
    acc(13'h0F0F, 1'b0, 0, "R4 write 0000 no series");

    // restart on stray 0000
    acc(13'h0000, 1'b0, 0, "R5 restart");
    acc(13'h1555, 1'b0, 0, "R5 restart");
    full_save("R5 restart at step two");
    prefix(0, 3, "R5 restart late");
    prefix(0, 5, "R5 restart late");
    acc(13'h0F0E, 1'b0, 2, "R5 restart after step three");

    // chip enable held low counts once (R6)
    @(negedge clk); ce_n = 1'b0; addr = key(0);
    repeat (3) @(negedge clk);
    addr = key(1);
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    prefix(2, 5, "R6 held strobe");
    acc(13'h0F0F, 1'b0, 0, "R6 held low counted once");

    // hiz holds while ce stays low (R9)
    prefix(0, 5, "R9 prefix");
    @(negedge clk); ce_n = 1'b0; addr = 13'h0F0F;
    @(negedge clk);
    check(save_req, 1'b1, "R2 save held strobe");
    repeat (3) begin
      @(negedge clk);
      check(hiz, 1'b1, "R9 hiz while ce low");
      check(save_req, 1'b0, "R10 single pulse while ce low");
    end
    ce_n = 1'b1;
    @(negedge clk);
    check(hiz, 1'b0, "R9 hiz after ce high");

    // busy clears progress (R7)
    prefix(0, 5, "R7 prefix");
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    acc(13'h0F0F, 1'b0, 0, "R7 busy cleared progress");
    prefix(0, 5, "R7 prefix 2");
    busy = 1'b1;
    acc(13'h0F0E, 1'b0, 0, "R7 busy at sixth");
    busy = 1'b0;
    prefix(0, 2, "R7 prefix 3");
    busy = 1'b1;
    acc(key(2), 1'b0, 0, "R7 busy mid series");
    busy = 1'b0;
    prefix(3, 5, "R7 rest");
    acc(13'h0F0F, 1'b0, 0, "R7 busy step not counted");
    full_save("R7 recovery");

    // low supply inhibit (R8)
    lowsup = 1'b1;
    full_save("R8 save withheld");
    prefix(0, 5, "R8 prefix");
    acc(13'h0F0E, 1'b0, 2, "R8 restore allowed");
    lowsup = 1'b0;
    full_save("R8 save after inhibit");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule